// File: doc/BRIEF.md
# Tag-Renaming Issue Scheduler with Broadcast Result Bus

This block accepts decoded arithmetic operations in program order and places each into a free holding slot of the right kind. There are two groups of slots: a small adder group, which handles add and subtract, and a multiplier group. A per-register rename table records which slot will produce the next value of every architectural register. When an operation enters a slot, each source is captured either as a ready value or as the 4-bit tag of the slot that will produce it. The destination register is then renamed to the new slot's tag. Because sources are copied at entry and every destination gets a fresh tag, write-after-read and write-after-write conflicts never hold back issue. The only reason to stall is that no slot of the needed kind is free.

A slot starts its fixed-latency countdown as soon as both of its operands are present. When the countdown ends, it asks for the single result bus. One request per cycle is granted, and the lowest tag has priority. The granted slot drives its tag and value on the bus, and all waiting slots and the register file pick the value up. The winning slot becomes free at that same edge. A register accepts a broadcast only while its rename entry still names the broadcasting tag. An operation that enters a slot in the very cycle its producer is on the bus takes the value straight from the bus.

Top module: `rs_sched`

## Requirements
- R1: After reset every slot is free, `in_ready` is 1, `cdb_valid` is 0, register i holds the value i+1 and no register has a pending write.
- R2: `in_ready` is 0 only when every slot of the kind needed by `in_op` is busy. `in_op` 2 needs a multiplier slot; 0, 1 and 3 need an adder slot. An operation offered while `in_ready` is 0 is not taken, and it is taken once a slot of its kind frees.
- R3: Adder slots carry tags 1 to NUM_ADD and multiplier slots carry the tags that follow. A new operation takes the lowest-tagged free slot of its kind. Tag 0 is never broadcast.
- R4: A source whose register has no pending write is captured as a value. Otherwise the producer's tag is captured and the value is taken from the bus later. If that producer is on the bus in the issue cycle itself, the bus value is captured directly.
- R5: `in_op` encodes the operation: 0 is add, 1 is subtract (src_a minus src_b), 2 is multiply and 3 acts as add. Results wrap modulo 2^DATA_W. With both operands ready at issue, the result is on the bus ADD_LAT+1 (adder) or MUL_LAT+1 (multiplier) clock edges after the accepting edge.
- R6: At most one result is broadcast per cycle, and the lowest requesting tag wins. A slot that loses keeps its result unchanged and is broadcast in a later cycle. A slot becomes free at the edge where its result is broadcast.
- R7: A register takes a broadcast value and clears its pending mark only if its rename entry equals the broadcast tag. When two writes to one register are in flight, the younger one's value is the one that remains.
- R8: Once all work has drained, the register file equals the result of executing the accepted operations one at a time in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head operation is offered |
| in_op | input | 2 | Operation code: 0 add, 1 subtract, 2 multiply, 3 add |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src_a | input | $clog2(NREG) | First source register |
| in_src_b | input | $clog2(NREG) | Second source register |
| in_ready | output | 1 | A slot of the needed kind is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | 4 | Tag of the broadcasting slot |
| cdb_value | output | DATA_W | Broadcast result value |
| obs_addr | input | $clog2(NREG) | Register selected for observation |
| obs_value | output | DATA_W | Current value of the observed register |
| obs_pending | output | 1 | Observed register awaits a broadcast |

## Verification
The main function is run with an operation stream that mixes true dependences, reuse of a source register as a later destination, and repeated writes to one register. The final register file is compared against an in-order model, which separates correct renaming from operand capture that happens too late or too early. Separate patterns isolate single effects. A lone operation per unit measures the latency. Two units finishing in the same cycle show the priority and that the loser holds its result. A long write followed by a short write to one register shows that the stale result is dropped. A consumer issued in the exact broadcast cycle of its producer shows that the bus bypass works. Dependent operations that fill the adder group show that a stall is tied to the kind of slot needed.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int TAG_W = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_AD2 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_EXEC = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LAT    = 2,
    parameter bit IS_MUL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  op_e               op_i,
    input  logic [DATA_W-1:0] vj_i,
    input  logic [TAG_W-1:0]  qj_i,
    input  logic [DATA_W-1:0] vk_i,
    input  logic [TAG_W-1:0]  qk_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_value_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              req_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic              busy;
        op_e               op;
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
        logic [DATA_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.qj != '0 && cdb_valid_i && cdb_tag_i == st_q.qj) begin
                st_d.vj = cdb_value_i;
                st_d.qj = '0;
            end
            if (st_q.qk != '0 && cdb_valid_i && cdb_tag_i == st_q.qk) begin
                st_d.vk = cdb_value_i;
                st_d.qk = '0;
            end
            unique case (st_q.ph)
                PH_WAIT: begin
                    if (st_q.qj == '0 && st_q.qk == '0) begin
                        st_d.ph  = PH_EXEC;
                        st_d.cnt = CNT_W'(LAT - 1);
                    end
                end
                PH_EXEC: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph = PH_DONE;
                        if (IS_MUL)
                            st_d.res = st_q.vj * st_q.vk;
                        else if (st_q.op == OP_SUB)
                            st_d.res = st_q.vj - st_q.vk;
                        else
                            st_d.res = st_q.vj + st_q.vk;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_DONE: begin
                    if (grant_i) begin
                        st_d.busy = 1'b0;
                        st_d.ph   = PH_WAIT;
                    end
                end
                default: st_d.ph = PH_WAIT;
            endcase
        end
        if (alloc_i) begin
            st_d.busy = 1'b1;
            st_d.op   = op_i;
            st_d.ph   = PH_WAIT;
            st_d.cnt  = '0;
            st_d.vj   = vj_i;
            st_d.qj   = qj_i;
            st_d.vk   = vk_i;
            st_d.qk   = qk_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o   = st_q.busy;
    assign req_o    = st_q.busy && st_q.ph == PH_DONE;
    assign result_o = st_q.res;

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !st_q.busy); // R2
    AST_EXEC_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.ph == PH_EXEC) |-> (st_q.qj == '0 && st_q.qk == '0)); // R4
    AST_LOSER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !grant_i) |=> (req_o && $stable(result_o))); // R6
    AST_FREE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && grant_i && !alloc_i) |=> !busy_o); // R6
endmodule

// File: rtl/rs_arbiter.sv
module rs_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    assign grant_o = req_i & (~req_i + 1'b1);
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra_i,
    input  logic [$clog2(NREG)-1:0] rb_i,
    input  logic [$clog2(NREG)-1:0] rc_i,
    output logic [DATA_W-1:0]       va_o,
    output logic [TAG_W-1:0]        qa_o,
    output logic [DATA_W-1:0]       vb_o,
    output logic [TAG_W-1:0]        qb_o,
    output logic [DATA_W-1:0]       vc_o,
    output logic                    pc_o,
    input  logic                    iss_we_i,
    input  logic [$clog2(NREG)-1:0] iss_dst_i,
    input  logic [TAG_W-1:0]        iss_tag_i,
    input  logic                    cdb_valid_i,
    input  logic [TAG_W-1:0]        cdb_tag_i,
    input  logic [DATA_W-1:0]       cdb_value_i
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] val;
        logic [NREG-1:0][TAG_W-1:0]  qi;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NREG; i++) begin
            if (cdb_valid_i && rf_q.qi[i] != '0 && rf_q.qi[i] == cdb_tag_i) begin
                rf_d.val[i] = cdb_value_i;
                rf_d.qi[i]  = '0;
            end
        end
        if (iss_we_i) rf_d.qi[iss_dst_i] = iss_tag_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                rf_q.val[i] <= DATA_W'(i + 1);
                rf_q.qi[i]  <= '0;
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    assign va_o = rf_q.val[ra_i];
    assign qa_o = rf_q.qi[ra_i];
    assign vb_o = rf_q.val[rb_i];
    assign qb_o = rf_q.qi[rb_i];
    assign vc_o = rf_q.val[rc_i];
    assign pc_o = rf_q.qi[rc_i] != '0;

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid_i && rf_q.qi[g] != cdb_tag_i) |=> $stable(rf_q.val[g])); // R7
    end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
    import rs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NREG    = 8,
    parameter int NUM_ADD = 3,
    parameter int NUM_MUL = 2,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_op,
    input  logic [$clog2(NREG)-1:0] in_dst,
    input  logic [$clog2(NREG)-1:0] in_src_a,
    input  logic [$clog2(NREG)-1:0] in_src_b,
    output logic                    in_ready,
    output logic                    cdb_valid,
    output logic [3:0]              cdb_tag,
    output logic [DATA_W-1:0]       cdb_value,
    input  logic [$clog2(NREG)-1:0] obs_addr,
    output logic [DATA_W-1:0]       obs_value,
    output logic                    obs_pending
);
    localparam int NST = NUM_ADD + NUM_MUL;

    logic [NST-1:0]    st_busy, st_req, grant, pick, alloc;
    logic [DATA_W-1:0] st_res [NST];
    logic [TAG_W-1:0]  pick_tag;
    logic              found, is_mul, iss_we;
    logic [DATA_W-1:0] ra_v, rb_v, vj, vk;
    logic [TAG_W-1:0]  ra_q, rb_q, qj, qk;

    assign is_mul = (in_op == 2'd2);

    always_comb begin
        pick     = '0;
        found    = 1'b0;
        pick_tag = '0;
        for (int s = 0; s < NST; s++) begin
            if (!found && !st_busy[s] && ((s >= NUM_ADD) == is_mul)) begin
                pick[s]  = 1'b1;
                found    = 1'b1;
                pick_tag = TAG_W'(s + 1);
            end
        end
    end

    assign in_ready = found;
    assign iss_we   = in_valid && found;
    assign alloc    = iss_we ? pick : '0;

    always_comb begin
        vj = ra_v;
        qj = ra_q;
        if (ra_q != '0 && cdb_valid && cdb_tag == ra_q) begin
            vj = cdb_value;
            qj = '0;
        end
        vk = rb_v;
        qk = rb_q;
        if (rb_q != '0 && cdb_valid && cdb_tag == rb_q) begin
            vk = cdb_value;
            qk = '0;
        end
    end

    rs_regstat #(.DATA_W(DATA_W), .NREG(NREG)) i_regstat (
        .clk(clk), .rst_n(rst_n),
        .ra_i(in_src_a), .rb_i(in_src_b), .rc_i(obs_addr),
        .va_o(ra_v), .qa_o(ra_q), .vb_o(rb_v), .qb_o(rb_q),
        .vc_o(obs_value), .pc_o(obs_pending),
        .iss_we_i(iss_we), .iss_dst_i(in_dst), .iss_tag_i(pick_tag),
        .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value)
    );

    for (genvar s = 0; s < NST; s++) begin : g_st
        localparam bit MUL_G = (s >= NUM_ADD);
        rs_station #(
            .DATA_W(DATA_W),
            .LAT   (MUL_G ? MUL_LAT : ADD_LAT),
            .IS_MUL(MUL_G)
        ) i_st (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc[s]), .op_i(op_e'(in_op)),
            .vj_i(vj), .qj_i(qj), .vk_i(vk), .qk_i(qk),
            .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value),
            .grant_i(grant[s]),
            .busy_o(st_busy[s]), .req_o(st_req[s]), .result_o(st_res[s])
        );
    end

    rs_arbiter #(.N(NST)) i_arb (.req_i(st_req), .grant_o(grant));

    always_comb begin
        cdb_value = '0;
        cdb_tag   = '0;
        for (int s = 0; s < NST; s++) begin
            if (grant[s]) begin
                cdb_value = st_res[s];
                cdb_tag   = TAG_W'(s + 1);
            end
        end
    end

    assign cdb_valid = |st_req;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> (cdb_tag != '0 && int'(cdb_tag) <= NST)); // R3
    AST_ISSUE_RENAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_we && obs_addr == in_dst) |=> obs_pending); // R7
endmodule

// File: tb/test_rs_sched.sv
`timescale 1ns/1ps
module test_rs_sched;
    localparam int DATA_W  = 16;
    localparam int NREG    = 8;
    localparam int NUM_ADD = 3;
    localparam int NUM_MUL = 2;
    localparam int ADD_LAT = 2;
    localparam int MUL_LAT = 4;
    localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, MUL = 2'd2;

    // {op[10:9], dst[8:6], src_a[5:3], src_b[2:0]}
    localparam logic [10:0] VEC [16] = '{
        {2'd2, 3'd1, 3'd2, 3'd3}, {2'd0, 3'd4, 3'd1, 3'd2},
        {2'd0, 3'd2, 3'd5, 3'd6}, {2'd1, 3'd1, 3'd4, 3'd7},
        {2'd2, 3'd5, 3'd1, 3'd1}, {2'd0, 3'd6, 3'd6, 3'd6},
        {2'd1, 3'd7, 3'd0, 3'd5}, {2'd2, 3'd0, 3'd7, 3'd4},
        {2'd3, 3'd3, 3'd0, 3'd0}, {2'd2, 3'd3, 3'd3, 3'd2},
        {2'd0, 3'd1, 3'd3, 3'd1}, {2'd1, 3'd2, 3'd2, 3'd1},
        {2'd0, 3'd4, 3'd4, 3'd4}, {2'd2, 3'd6, 3'd5, 3'd4},
        {2'd1, 3'd0, 3'd6, 3'd7}, {2'd0, 3'd5, 3'd0, 3'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_op = '0;
    logic [2:0] in_dst = '0, in_src_a = '0, in_src_b = '0, obs_addr = '0;
    logic in_ready, cdb_valid, obs_pending;
    logic [3:0] cdb_tag;
    logic [DATA_W-1:0] cdb_value, obs_value;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int acc = 0;
    logic [DATA_W-1:0] mreg [NREG];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rs_sched #(.DATA_W(DATA_W), .NREG(NREG), .NUM_ADD(NUM_ADD), .NUM_MUL(NUM_MUL),
               .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) i_rs_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_ready(in_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_value(cdb_value), .obs_addr(obs_addr), .obs_value(obs_value),
        .obs_pending(obs_pending)
    );

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic drive_issue(input logic [1:0] op, input int dst, input int a, input int b);
        in_valid = 1'b1;
        in_op    = op;
        in_dst   = 3'(dst);
        in_src_a = 3'(a);
        in_src_b = 3'(b);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        case (op)
            MUL:     mreg[dst] = mreg[a] * mreg[b];
            SUB:     mreg[dst] = mreg[a] - mreg[b];
            default: mreg[dst] = mreg[a] + mreg[b];
        endcase
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input int dst, input int a, input int b);
        @(negedge clk);
        drive_issue(op, dst, a, b);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic drain();
        repeat (200) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            obs_addr = 3'(r);
            #1;
            check(obs_value == mreg[r], req, obs_value, mreg[r]);
            check(obs_pending == 1'b0, req, obs_pending, 0);
        end
    endtask

    initial begin
        int t0, m, p;
        logic [DATA_W-1:0] ea, em;
        for (int r = 0; r < NREG; r++) mreg[r] = DATA_W'(r + 1);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);
        check(cdb_valid == 1'b0, "R1 bus idle", cdb_valid, 0);
        check_all("R1");

        // R5 / R3: adder latency, tag and value
        issue(ADD, 1, 2, 3);
        t0 = acc;
        ea = mreg[1];
        do @(negedge clk); while (!cdb_valid && cyc < t0 + 60);
        check(cyc - t0 == ADD_LAT + 1, "R5 add latency", cyc - t0, ADD_LAT + 1);
        check(cdb_tag == 4'd1, "R3 add tag", cdb_tag, 1);
        check(cdb_value == ea, "R5 add value", cdb_value, ea);
        drain();

        // R5 / R3: multiplier latency, tag and value
        issue(MUL, 2, 3, 4);
        t0 = acc;
        em = mreg[2];
        do @(negedge clk); while (!cdb_valid && cyc < t0 + 60);
        check(cyc - t0 == MUL_LAT + 1, "R5 mul latency", cyc - t0, MUL_LAT + 1);
        check(cdb_tag == 4'(NUM_ADD + 1), "R3 mul tag", cdb_tag, NUM_ADD + 1);
        check(cdb_value == em, "R5 mul value", cdb_value, em);
        drain();

        // R5: subtract wraps, code 3 adds
        issue(SUB, 3, 0, 7);
        issue(2'd3, 6, 3, 5);
        drain();
        check_all("R5");

        // R4: consumer issued in the producer's broadcast cycle
        issue(ADD, 5, 1, 1);
        p = acc;
        do @(negedge clk); while (!(cdb_valid && cdb_tag == 4'd1) && cyc < p + 60);
        drive_issue(ADD, 6, 5, 5);
        check(acc == p + ADD_LAT + 2, "R4 bypass timing", acc, p + ADD_LAT + 2);
        drain();
        check_all("R4");

        // R6: two results ready in one cycle
        issue(MUL, 1, 2, 3);
        m = acc;
        em = mreg[1];
        @(negedge clk);
        issue(ADD, 4, 5, 6);
        ea = mreg[4];
        wait_cyc(m + MUL_LAT + 1);
        check(cdb_valid && cdb_tag == 4'd1, "R6 low tag wins", cdb_tag, 1);
        check(cdb_value == ea, "R6 winner value", cdb_value, ea);
        wait_cyc(m + MUL_LAT + 2);
        check(cdb_valid && cdb_tag == 4'(NUM_ADD + 1), "R6 loser later", cdb_tag, NUM_ADD + 1);
        check(cdb_value == em, "R6 loser held", cdb_value, em);
        drain();
        check_all("R6");

        // R7: older long write then younger short write to r3
        obs_addr = 3'd3;
        issue(MUL, 3, 2, 4);
        m = acc;
        issue(ADD, 3, 1, 1);
        ea = mreg[3];
        wait_cyc(m + MUL_LAT + 1);
        #1;
        check(obs_value == ea, "R7 younger value", obs_value, ea);
        check(obs_pending == 1'b0, "R7 pending cleared", obs_pending, 0);
        check(cdb_valid && cdb_tag == 4'(NUM_ADD + 1), "R7 old on bus", cdb_tag, NUM_ADD + 1);
        wait_cyc(m + MUL_LAT + 2);
        #1;
        check(obs_value == ea, "R7 stale dropped", obs_value, ea);
        drain();
        check_all("R7");

        // R2: adder group full of waiting work, multiplier still free
        issue(MUL, 1, 2, 3);
        issue(ADD, 4, 1, 2);
        issue(ADD, 5, 1, 3);
        issue(ADD, 6, 1, 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = ADD;
        #1;
        check(in_ready == 1'b0, "R2 add stall", in_ready, 0);
        in_op = MUL;
        #1;
        check(in_ready == 1'b1, "R2 mul free", in_ready, 1);
        in_valid = 1'b0;
        issue(ADD, 7, 1, 6);
        drain();
        check_all("R2");

        // R8: mixed stream against in-order model
        for (int k = 0; k < 16; k++)
            issue(VEC[k][10:9], int'(VEC[k][8:6]), int'(VEC[k][5:3]), int'(VEC[k][2:0]));
        drain();
        check_all("R8");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule